// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads a configuration image into a downstream programmable device over a passive serial link. A host gives the image length and timing settings, pulses a start command, and then streams the image one byte at a time through a valid/ready handshake. The block first prepares the configuration chain. It holds the target in reset, releases it, and waits a settle time. It then shifts every byte out on a serial data line, least significant bit first. A divided-down serial clock goes with the data, and the target captures each bit on the rising edge of that clock.

After the last byte the block keeps clocking the target for a programmable number of extra cycles, with data held low. It then watches the target's status and done lines, which are both low when good. It reports success when both are low, or failure when its timeout runs out. Progress pulses mark every fortieth of the image. An abort request is sampled only at those points. Both abort and success release the chain-select line.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset, tgt_cfg_o, sclk_o, sdata_o, chain_en_o, busy_o, success_o, fail_o, ready_o and progress_o are 0, and chain_sel_o is 1.
- R2: From the cycle after start_i is taken in idle until busy_o falls, chain_en_o is 1 and chain_sel_o is 0. chain_en_o then stays 1.
- R3: tgt_cfg_o is 0 for exactly max(hold_i,1) cycles after start, then goes to 1. The first rising edge of sclk_o comes at least max(settle_i,1) cycles after that.
- R4: A byte is taken only on a cycle with ready_o and valid_i both high. Each byte gives exactly 8 rising edges of sclk_o, and sdata_o carries bit 0 first and bit 7 last.
- R5: Each high phase of sclk_o lasts exactly max(div_i,1) cycles, and each low phase within a byte lasts the same time. sdata_o is stable while sclk_o is high. sclk_o is 0 whenever busy_o is 0.
- R6: progress_o pulses for one cycle after each byte whose 1-based count is a multiple of step = max(len_i/40,1).
- R7: After the last byte, sclk_o gives exactly tail_i further rising edges with sdata_o at 0. With len_i = 0, only these tail edges appear.
- R8: In the check phase, tgt_done_i = 0 together with tgt_status_i = 0 ends the load. busy_o falls, success_o goes to 1 and chain_sel_o goes to 1.
- R9: While tgt_status_i = 1 or tgt_done_i = 1, success is withheld. After timeout_i+1 check cycles, fail_o goes to 1 and busy_o falls.
- R10: If abort_i is 1 when a checkpoint byte (see R6) completes, the load ends at once. fail_o goes to 1, chain_sel_o goes to 1, and no further sclk_o edges follow.
- R11: abort_i has no effect at any time other than a checkpoint byte completion. A load with abort_i high only during the reset phase completes with success and the full edge count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken while idle |
| len_i | input | LEN_W | Image length in bytes |
| abort_i | input | 1 | Abort request, sampled at checkpoints |
| hold_i | input | CNT_W | Minimum cycles to hold the target in reset |
| settle_i | input | CNT_W | Settle cycles after the reset release |
| div_i | input | DIV_W | System cycles per serial clock phase |
| tail_i | input | CNT_W | Extra serial clocks after the last byte |
| timeout_i | input | CNT_W | Check-phase timeout in cycles |
| data_i | input | BYTE_W | Image byte |
| valid_i | input | 1 | data_i valid |
| ready_o | output | 1 | Byte can be taken |
| tgt_cfg_o | output | 1 | Target configuration control (low = reset) |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |
| chain_en_o | output | 1 | Chain enable |
| chain_sel_o | output | 1 | Chain select (high = released) |
| tgt_status_i | input | 1 | Target status, high = fault |
| tgt_done_i | input | 1 | Target done, low = good |
| busy_o | output | 1 | Load in progress |
| success_o | output | 1 | Last load succeeded |
| fail_o | output | 1 | Last load failed |
| progress_o | output | 1 | Progress pulse |

## Verification
A wrong bit index or shift direction shows up on the very first byte as a mismatch between the captured serial bits and the image. A bad phase counter shows up within one serial clock period as a high phase of the wrong length. A wrong step or remainder in the progress tracker changes the count of progress pulses over a whole image, or moves the abort point, which in turn changes the count of serial edges before fail_o rises. Errors in the reset or settle counters appear before the first serial edge, as a wrong number of cycles with tgt_cfg_o low or too short a gap before the first edge.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_SETTLE,
    ST_LOAD,
    ST_TAIL,
    ST_CHECK
  } ps_state_e;
endpackage

// File: rtl/ps_sclk_gen.sv
module ps_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             cyc_end_o
);
  logic [DIV_W-1:0] cnt_q, lim;
  logic             lvl_q;

  assign lim = (div_i == '0) ? '0 : div_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (cnt_q == lim) begin
      cnt_q <= '0;
      lvl_q <= ~lvl_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sclk_o    = lvl_q;
  // last cycle of the high phase closes one serial period
  assign cyc_end_o = en_i && lvl_q && (cnt_q == lim);
endmodule

// File: rtl/ps_shift_reg.sv
module ps_shift_reg #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              shift_i,
  output logic              full_o,
  output logic              bit_o,
  output logic              byte_done_o
);
  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sr_q;
  logic [IDX_W-1:0]  idx_q;
  logic              full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      idx_q  <= '0;
      full_q <= 1'b0;
    end else if (load_i) begin
      sr_q   <= byte_i;
      idx_q  <= '0;
      full_q <= 1'b1;
    end else if (shift_i && full_q) begin
      sr_q  <= sr_q >> 1;
      idx_q <= idx_q + 1'b1;
      if (idx_q == LAST_IDX) full_q <= 1'b0;
    end
  end

  assign full_o      = full_q;
  assign bit_o       = sr_q[0];
  assign byte_done_o = shift_i && full_q && (idx_q == LAST_IDX);
endmodule

// File: rtl/ps_progress.sv
module ps_progress #(
  parameter int LEN_W    = 16,
  parameter int PROG_DIV = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             byte_i,
  output logic             chk_o,
  output logic             last_o
);
  logic [LEN_W-1:0] step_q, sub_q, sent_q, len_q, step_d;

  assign step_d = len_i / LEN_W'(PROG_DIV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= LEN_W'(1);
      sub_q  <= '0;
      sent_q <= '0;
      len_q  <= '0;
    end else if (arm_i) begin
      step_q <= (step_d == '0) ? LEN_W'(1) : step_d;
      sub_q  <= '0;
      sent_q <= '0;
      len_q  <= len_i;
    end else if (byte_i) begin
      sub_q  <= chk_o ? '0 : sub_q + 1'b1;
      sent_q <= sent_q + 1'b1;
    end
  end

  assign chk_o  = (sub_q + 1'b1) == step_q;
  assign last_o = (sent_q + 1'b1) == len_q;
endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
  import ps_cfg_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int LEN_W    = 16,
  parameter int CNT_W    = 16,
  parameter int DIV_W    = 8,
  parameter int PROG_DIV = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              abort_i,
  input  logic [CNT_W-1:0]  hold_i,
  input  logic [CNT_W-1:0]  settle_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [CNT_W-1:0]  tail_i,
  input  logic [CNT_W-1:0]  timeout_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              tgt_cfg_o,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              chain_en_o,
  output logic              chain_sel_o,
  input  logic              tgt_status_i,
  input  logic              tgt_done_i,
  output logic              busy_o,
  output logic              success_o,
  output logic              fail_o,
  output logic              progress_o
);
  ps_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic cfg_q, en_q, sel_q, busy_q, ok_q, fail_q, prog_q;
  logic full, sh_bit, byte_done, cyc_end, clk_en, sh_load, chk, last;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign sh_load = ready_o && valid_i;
  assign clk_en  = ((state_q == ST_LOAD) && full) ||
                   ((state_q == ST_TAIL) && (cnt_q != tail_i));

  ps_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk_i, .rst_ni, .en_i(clk_en), .div_i,
    .sclk_o, .cyc_end_o(cyc_end)
  );

  ps_shift_reg #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i, .rst_ni, .load_i(sh_load), .byte_i(data_i),
    .shift_i(cyc_end && (state_q == ST_LOAD)),
    .full_o(full), .bit_o(sh_bit), .byte_done_o(byte_done)
  );

  ps_progress #(.LEN_W(LEN_W), .PROG_DIV(PROG_DIV)) u_prog (
    .clk_i, .rst_ni, .arm_i(start_i && (state_q == ST_IDLE)), .len_i,
    .byte_i(byte_done), .chk_o(chk), .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cfg_q   <= 1'b0;
      en_q    <= 1'b0;
      sel_q   <= 1'b1;
      busy_q  <= 1'b0;
      ok_q    <= 1'b0;
      fail_q  <= 1'b0;
      prog_q  <= 1'b0;
    end else begin
      prog_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_HOLD;
          cnt_q   <= '0;
          cfg_q   <= 1'b0;
          en_q    <= 1'b1;
          sel_q   <= 1'b0;
          busy_q  <= 1'b1;
          ok_q    <= 1'b0;
          fail_q  <= 1'b0;
        end
        ST_HOLD: if (cnt_inc >= {1'b0, hold_i}) begin
          cfg_q   <= 1'b1;
          cnt_q   <= '0;
          state_q <= ST_SETTLE;
        end else cnt_q <= cnt_inc[CNT_W-1:0];
        ST_SETTLE: if (cnt_inc >= {1'b0, settle_i}) begin
          cnt_q   <= '0;
          state_q <= (len_i == '0) ? ST_TAIL : ST_LOAD;
        end else cnt_q <= cnt_inc[CNT_W-1:0];
        ST_LOAD: if (byte_done) begin
          prog_q <= chk;
          if (chk && abort_i) begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
            sel_q   <= 1'b1;
            fail_q  <= 1'b1;
          end else if (last) begin
            state_q <= ST_TAIL;
            cnt_q   <= '0;
          end
        end
        ST_TAIL: if (cnt_q == tail_i) begin
          state_q <= ST_CHECK;
          cnt_q   <= '0;
        end else if (cyc_end) cnt_q <= cnt_inc[CNT_W-1:0];
        ST_CHECK: if (!tgt_done_i && !tgt_status_i) begin
          state_q <= ST_IDLE;
          busy_q  <= 1'b0;
          sel_q   <= 1'b1;
          ok_q    <= 1'b1;
        end else if (cnt_q == timeout_i) begin
          state_q <= ST_IDLE;
          busy_q  <= 1'b0;
          sel_q   <= 1'b1;
          fail_q  <= 1'b1;
        end else cnt_q <= cnt_inc[CNT_W-1:0];
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o     = (state_q == ST_LOAD) && !full;
  assign sdata_o     = (state_q == ST_LOAD) && full && sh_bit;
  assign tgt_cfg_o   = cfg_q;
  assign chain_en_o  = en_q;
  assign chain_sel_o = sel_q;
  assign busy_o      = busy_q;
  assign success_o   = ok_q;
  assign fail_o      = fail_q;
  assign progress_o  = prog_q;
endmodule

// File: rtl/ps_cfg_master_chk.sv
module ps_cfg_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ready_o,
  input logic tgt_cfg_o,
  input logic sclk_o,
  input logic sdata_o,
  input logic chain_en_o,
  input logic chain_sel_o,
  input logic busy_o,
  input logic success_o,
  input logic fail_o
);
  p_chain_setup_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (chain_en_o && !chain_sel_o));
  p_cfg_low_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !tgt_cfg_o);
  p_cfg_fall_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tgt_cfg_o) |-> $rose(busy_o));
  p_ready_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> busy_o);
  p_data_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));
  p_sclk_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);
  p_verdict_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(success_o && fail_o));
  p_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (chain_sel_o && (success_o || fail_o)));
endmodule

bind ps_cfg_master ps_cfg_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_o(ready_o), .tgt_cfg_o(tgt_cfg_o),
  .sclk_o(sclk_o), .sdata_o(sdata_o), .chain_en_o(chain_en_o),
  .chain_sel_o(chain_sel_o), .busy_o(busy_o), .success_o(success_o),
  .fail_o(fail_o)
);

// File: tb/tb_ps_cfg_master.sv
module tb_ps_cfg_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, abort = 1'b0, valid = 1'b0;
  logic [15:0] len = '0, hold = '0, settle = '0, tail = '0, tmo = '0;
  logic [7:0]  div = '0, data = '0;
  logic        tstat = 1'b0, tdone = 1'b0;
  logic ready, cfg, sclk, sdata, cen, csel, busy, ok, fl, prog;

  int n_chk = 0, n_fail = 0;
  int nrise, nprog, ncfg_low, nsettle, hi_run, hi_bad, stab_bad, chain_bad, exp_hi;
  logic held_bit, mon_en = 1'b0;
  logic cap [4096];

  always #2 clk = ~clk;

  ps_cfg_master dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len), .abort_i(abort),
    .hold_i(hold), .settle_i(settle), .div_i(div), .tail_i(tail), .timeout_i(tmo),
    .data_i(data), .valid_i(valid), .ready_o(ready), .tgt_cfg_o(cfg),
    .sclk_o(sclk), .sdata_o(sdata), .chain_en_o(cen), .chain_sel_o(csel),
    .tgt_status_i(tstat), .tgt_done_i(tdone), .busy_o(busy),
    .success_o(ok), .fail_o(fl), .progress_o(prog)
  );

  function automatic logic [7:0] img(int i);
    return 8'((i * 29) ^ 8'h5A);
  endfunction

  task automatic chk(bit cond, string tag, int act, int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge sclk) if (mon_en) begin
    if (nrise < 4096) cap[nrise] = sdata;
    held_bit = sdata;
    nrise++;
  end

  always @(negedge clk) if (mon_en) begin
    if (prog) nprog++;
    if (busy && !cfg) ncfg_low++;
    if (busy && cfg && nrise == 0) nsettle++;
    if (busy && !(cen && !csel)) chain_bad++;
    if (sclk) begin
      hi_run++;
      if (sdata !== held_bit) stab_bad++;
    end else if (hi_run != 0) begin
      if (hi_run != exp_hi) hi_bad++;
      hi_run = 0;
    end
  end

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // am: 0 no abort, 1 abort held, 2 abort only while target held in reset
  task automatic run_load(int l, int d, int h, int s, int t, int to, bit st, bit dn, int am);
    len = 16'(l); div = 8'(d); hold = 16'(h); settle = 16'(s);
    tail = 16'(t); tmo = 16'(to); tstat = st; tdone = dn;
    nrise = 0; nprog = 0; ncfg_low = 0; nsettle = 0; hi_run = 0;
    hi_bad = 0; stab_bad = 0; chain_bad = 0; exp_hi = (d == 0) ? 1 : d;
    mon_en = 1'b1;
    @(negedge clk); start = 1'b1; abort = (am != 0);
    @(negedge clk); start = 1'b0;
    fork
      begin
        for (int i = 0; i < l; i++) begin
          data = img(i); valid = 1'b1;
          while (!ready && busy) @(negedge clk);
          if (!busy) break;
          @(negedge clk);
        end
        valid = 1'b0;
      end
      begin
        if (am == 2) begin
          while (!cfg) @(negedge clk);
          abort = 1'b0;
        end
      end
      begin
        while (busy) @(negedge clk);
      end
    join
    abort = 1'b0; valid = 1'b0;
    @(negedge clk);
    mon_en = 1'b0;
  endtask

  function automatic int bit_errs(int l, int t);
    int e = 0;
    for (int b = 0; b < l; b++)
      for (int k = 0; k < 8; k++)
        if (cap[b*8+k] !== img(b)[k]) e++;
    for (int j = 0; j < t; j++)
      if (cap[l*8+j] !== 1'b0) e++;
    return e;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk({cfg, sclk, sdata, cen, csel, busy, ok, fl, ready, prog} == 10'b0000100000,
        "R1 reset state", int'({cfg, sclk, sdata, cen, csel, busy, ok, fl, ready, prog}),
        int'(10'b0000100000));
  endtask

  task automatic t_basic();
    run_load(5, 1, 6, 4, 10, 50, 1'b0, 1'b0, 0);
    chk(ncfg_low == 6, "R3 reset hold cycles", ncfg_low, 6);
    chk(nsettle >= 4, "R3 settle before first edge", nsettle, 4);
    chk(chain_bad == 0, "R2 chain setup during load", chain_bad, 0);
    chk(cen && csel, "R8 chain released, enable kept", int'({cen, csel}), 3);
    chk(nrise == 50, "R4 R7 serial edge count", nrise, 50);
    chk(bit_errs(5, 10) == 0, "R4 LSB-first data", bit_errs(5, 10), 0);
    chk(ok && !fl && !busy, "R8 success", int'({ok, fl, busy}), 4);
  endtask

  task automatic t_divider();
    run_load(3, 3, 2, 2, 2, 20, 1'b0, 1'b0, 0);
    chk(hi_bad == 0, "R5 high phase length", hi_bad, 0);
    chk(stab_bad == 0, "R5 data stable while high", stab_bad, 0);
    chk(nrise == 26 && bit_errs(3, 2) == 0, "R5 divided stream", nrise, 26);
  endtask

  task automatic t_progress();
    run_load(80, 1, 1, 1, 0, 10, 1'b0, 1'b0, 0);
    chk(nprog == 40, "R6 progress len 80", nprog, 40);
    run_load(7, 2, 1, 1, 0, 10, 1'b0, 1'b0, 0);
    chk(nprog == 7, "R6 progress short len", nprog, 7);
  endtask

  task automatic t_empty();
    run_load(0, 1, 2, 1, 5, 10, 1'b0, 1'b0, 0);
    chk(nrise == 5 && bit_errs(0, 5) == 0, "R7 empty image tail only", nrise, 5);
    chk(ok, "R7 empty image success", int'(ok), 1);
  endtask

  task automatic t_timeout();
    run_load(2, 1, 1, 1, 3, 20, 1'b1, 1'b0, 0);
    chk(fl && !ok && !busy, "R9 status fault fails", int'({fl, ok, busy}), 4);
    chk(nrise == 19, "R9 full stream before check", nrise, 19);
    run_load(2, 1, 1, 1, 3, 20, 1'b0, 1'b1, 0);
    chk(fl && !ok, "R9 done not reached fails", int'({fl, ok}), 2);
  endtask

  task automatic t_abort();
    run_load(80, 1, 2, 2, 4, 20, 1'b0, 1'b0, 1);
    chk(fl && !ok && !busy, "R10 abort fails", int'({fl, ok, busy}), 4);
    chk(nrise == 16, "R10 stop at first checkpoint", nrise, 16);
    chk(nprog == 1, "R10 one progress pulse", nprog, 1);
    chk(csel && !sclk, "R10 chain released", int'({csel, sclk}), 2);
  endtask

  task automatic t_abort_ignored();
    run_load(80, 1, 8, 2, 4, 20, 1'b0, 1'b0, 2);
    chk(ok && !fl, "R11 abort outside checkpoint ignored", int'({ok, fl}), 2);
    chk(nrise == 644, "R11 full stream", nrise, 644);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_divider();
    t_progress();
    t_empty();
    t_timeout();
    t_abort();
    t_abort_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule